// File: doc/BRIEF.md
# Linked-Descriptor Two-Channel DMA Engine

This block moves 32-bit words between memory and a peripheral address on behalf of two independent channels. Software sets up a channel through a small register window. It writes a pointer to a four-word descriptor, then enables the channel with a fetch request. The channel reads the descriptor, which holds the byte count, source, destination and link to the next descriptor. It then copies the data one word at a time, reading from the source and writing to the destination. Each side either steps forward by 4 bytes per beat or stays on one address, which suits a peripheral FIFO register.

When a descriptor's byte count reaches zero, the channel raises its completion status and fetches the linked descriptor. A chain whose last link points back to its head therefore runs as a ring until software stops it. A link of zero ends the chain. Both channels share one single-beat memory port. A channel holds the port for one burst of beats, or for one descriptor fetch, and then releases it. When both channels are waiting, the port goes round-robin between them.

Each channel runs a four-state machine. The states are CH_IDLE, CH_FETCH, CH_READ and CH_WRITE, and the transitions are:
- CH_IDLE to CH_FETCH: granted, with a fetch pending.
- CH_IDLE to CH_READ: granted, with bytes left and no fetch pending.
- CH_FETCH to CH_IDLE: the fourth descriptor word has been accepted.
- CH_READ to CH_WRITE: the source read has been accepted.
- CH_WRITE to CH_READ: the write has been accepted, the burst has room left and the channel is still enabled.
- CH_WRITE to CH_IDLE: the write has been accepted at the end of a burst, at the end of the descriptor, or with the channel disabled.
- Any state to CH_IDLE: abort.

Top module: `tdma_top`

## Requirements
- R1: After reset, every register reads zero, both interrupt outputs are low and no memory request is made.
- R2: The register address is formed as {slot[3:0], channel[1:0], 2'b00}. The slots are: 0 count, 1 source, 2 destination, 3 next pointer, 4 control, 7 current descriptor (read-only), 8 mask, 10 status. A write to one channel leaves the other channel's registers unchanged.
- R3: With control bit 12 (enable) set, setting control bit 13 makes the channel read words at next, next+4, next+8 and next+12 into count, source, destination and next pointer, in that order. The current-descriptor register then holds the address that was fetched.
- R4: The source mode is control bits 3:2 and the destination mode is control bits 5:4. Mode 0 advances that address by 4 after each beat. Mode 2 keeps the address fixed.
- R5: Control bits 8:6 give the beats per burst: 0 gives 1 beat, 1 gives 2, 3 gives 4, 6 gives 8, 7 gives 16 and 5 gives 32. A channel holds the memory port for at most one burst. When both channels are waiting, the port alternates between them.
- R6: The count register falls by 4 per beat and can be read at any time. Any count above 65536 written or fetched is held at 65536.
- R7: When a descriptor's count reaches zero, status bit 0 is set. The channel interrupt is status AND mask bit 0, and irq_any is the OR of the channel interrupts. Writing 0 to status bit 0 clears it; writing 1 has no effect.
- R8: After completion, the channel fetches the descriptor at its next pointer and carries on, so a circular list repeats indefinitely. A next pointer of zero leaves the channel idle.
- R9: Clearing enable stops the channel at the end of the current beat, with count and addresses kept. Setting enable again continues from that point.
- R10: Writing control bit 20 returns the channel to idle at once, dropping any open request. It also clears enable, any pending fetch and the count. Bit 20 reads back as zero.
- R11: Control bit 14 reads 1 while the channel is executing or has enabled work pending, and 0 otherwise. Writes to bit 14 have no effect.
- R12: A memory request keeps its address and direction unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 2 | Per-channel completion interrupt |
| irq_any | output | 1 | OR of the channel interrupts |

## Verification
The assertions assume the following about the inputs:
- Software does not rewrite a channel's count, source, destination or next pointer while that channel is outside CH_IDLE.
- Byte counts are multiples of 4.
- The memory raises mem_ack only while a request is open.

The request-stability property would fail if a working address were overwritten in the middle of a beat. The directed stimulus therefore loads descriptors only through fetches, and changes control fields only for pause, resume or abort. Descriptors and data buffers sit at word-aligned addresses, and the memory model acknowledges one cycle after each new request.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_FETCH,
        CH_READ,
        CH_WRITE
    } ch_state_e;

    localparam int unsigned BEAT_BYTES = 4;

    localparam logic [3:0] SLOT_COUNT = 4'd0;
    localparam logic [3:0] SLOT_SRC   = 4'd1;
    localparam logic [3:0] SLOT_DST   = 4'd2;
    localparam logic [3:0] SLOT_NEXT  = 4'd3;
    localparam logic [3:0] SLOT_CTRL  = 4'd4;
    localparam logic [3:0] SLOT_CUR   = 4'd7;
    localparam logic [3:0] SLOT_MASK  = 4'd8;
    localparam logic [3:0] SLOT_STAT  = 4'd10;

    localparam int CB_EN    = 12;
    localparam int CB_FETCH = 13;
    localparam int CB_ACT   = 14;
    localparam int CB_ABORT = 20;

    function automatic logic [5:0] burst_beats(input logic [2:0] code);
        logic [5:0] n;
        unique case (code)
            3'd1:    n = 6'd2;
            3'd3:    n = 6'd4;
            3'd6:    n = 6'd8;
            3'd7:    n = 6'd16;
            3'd5:    n = 6'd32;
            default: n = 6'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tdma_arbiter.sv
module tdma_arbiter #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] want,
    input  logic [NCH-1:0] busy,
    output logic [NCH-1:0] gnt
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [IW-1:0] last_q;
    logic [IW-1:0] pick;
    logic          found;

    // Grant only while the port is free, searching from the channel after the last owner.
    always_comb begin
        gnt   = '0;
        pick  = last_q;
        found = 1'b0;
        if (busy == '0) begin
            for (int k = 1; k <= NCH; k++) begin
                if (!found && want[(int'(last_q) + k) % NCH]) begin
                    found = 1'b1;
                    gnt[(int'(last_q) + k) % NCH] = 1'b1;
                    pick = IW'((int'(last_q) + k) % NCH);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     last_q <= '0;
        else if (found) last_q <= pick;
    end

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy)); // R5

endmodule

// File: rtl/tdma_channel.sv
module tdma_channel
    import tdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_BYTES = 65536
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_slot,
    input  logic [31:0]   wr_data,
    input  logic [3:0]    rd_slot,
    output logic [31:0]   rd_data,
    input  logic          gnt,
    output logic          want,
    output logic          busy,
    output logic          req_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [31:0]   wdata_o,
    input  logic          ack_i,
    input  logic [31:0]   rdata_i,
    output logic          irq_o
);
    localparam int CW = $clog2(MAX_BYTES) + 1;

    ch_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] src_q, dst_q, nd_q, cur_q;
    logic [1:0]    srcm_q, dstm_q;
    logic [2:0]    bsz_q;
    logic          en_q, fetch_q, mask_q, stat_q;
    logic [1:0]    widx_q;
    logic [5:0]    beat_q;
    logic [31:0]   buf_q;

    logic          abort_now, last_beat, burst_end, active;
    logic [AW-1:0] sstep, dstep;

    function automatic logic [CW-1:0] clamp_cnt(input logic [31:0] w);
        if (w > 32'(MAX_BYTES)) return CW'(MAX_BYTES);
        return w[CW-1:0];
    endfunction

    assign abort_now = wr_en && (wr_slot == SLOT_CTRL) && wr_data[CB_ABORT];
    assign last_beat = (cnt_q <= CW'(BEAT_BYTES));
    assign burst_end = (beat_q == burst_beats(bsz_q) - 6'd1);
    assign sstep     = srcm_q[1] ? '0 : AW'(BEAT_BYTES);
    assign dstep     = dstm_q[1] ? '0 : AW'(BEAT_BYTES);
    assign want      = (st_q == CH_IDLE) && en_q && (fetch_q || cnt_q != '0);
    assign busy      = (st_q != CH_IDLE);
    assign active    = busy || want;
    assign irq_o     = stat_q & mask_q;

    // Next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE:  if (want && gnt) st_d = fetch_q ? CH_FETCH : CH_READ;
            CH_FETCH: if (ack_i && widx_q == 2'd3) st_d = CH_IDLE;
            CH_READ:  if (ack_i) st_d = CH_WRITE;
            CH_WRITE: if (ack_i) st_d = (last_beat || burst_end || !en_q) ? CH_IDLE : CH_READ;
        endcase
        if (abort_now) st_d = CH_IDLE;
    end

    // Output process
    always_comb begin
        req_o   = 1'b0;
        we_o    = 1'b0;
        addr_o  = dst_q;
        wdata_o = buf_q;
        unique case (st_q)
            CH_IDLE:  ;
            CH_FETCH: begin req_o = 1'b1; addr_o = cur_q + AW'({widx_q, 2'b00}); end
            CH_READ:  begin req_o = 1'b1; addr_o = src_q; end
            CH_WRITE: begin req_o = 1'b1; we_o = 1'b1; end
        endcase
    end

    always_comb begin
        rd_data = '0;
        case (rd_slot)
            SLOT_COUNT: rd_data = 32'(cnt_q);
            SLOT_SRC:   rd_data = 32'(src_q);
            SLOT_DST:   rd_data = 32'(dst_q);
            SLOT_NEXT:  rd_data = 32'(nd_q);
            SLOT_CTRL: begin
                rd_data[3:2]     = srcm_q;
                rd_data[5:4]     = dstm_q;
                rd_data[8:6]     = bsz_q;
                rd_data[CB_EN]    = en_q;
                rd_data[CB_FETCH] = fetch_q;
                rd_data[CB_ACT]   = active;
            end
            SLOT_CUR:   rd_data = 32'(cur_q);
            SLOT_MASK:  rd_data = {31'b0, mask_q};
            SLOT_STAT:  rd_data = {31'b0, stat_q};
            default:    rd_data = '0;
        endcase
    end

    // State register and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= CH_IDLE;
            cnt_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            nd_q    <= '0;
            cur_q   <= '0;
            srcm_q  <= '0;
            dstm_q  <= '0;
            bsz_q   <= '0;
            en_q    <= 1'b0;
            fetch_q <= 1'b0;
            mask_q  <= 1'b0;
            stat_q  <= 1'b0;
            widx_q  <= '0;
            beat_q  <= '0;
            buf_q   <= '0;
        end else begin
            st_q <= st_d;
            if (wr_en) begin
                case (wr_slot)
                    SLOT_COUNT: cnt_q <= clamp_cnt(wr_data);
                    SLOT_SRC:   src_q <= AW'(wr_data);
                    SLOT_DST:   dst_q <= AW'(wr_data);
                    SLOT_NEXT:  nd_q  <= AW'(wr_data);
                    SLOT_CTRL: begin
                        srcm_q <= wr_data[3:2];
                        dstm_q <= wr_data[5:4];
                        bsz_q  <= wr_data[8:6];
                        en_q   <= wr_data[CB_EN];
                        if (wr_data[CB_FETCH]) fetch_q <= 1'b1;
                    end
                    SLOT_MASK:  mask_q <= wr_data[0];
                    SLOT_STAT:  if (!wr_data[0]) stat_q <= 1'b0;
                    default: ;
                endcase
            end
            unique case (st_q)
                CH_IDLE: if (want && gnt) begin
                    beat_q <= '0;
                    widx_q <= '0;
                    if (fetch_q) cur_q <= nd_q;
                end
                CH_FETCH: if (ack_i) begin
                    widx_q <= widx_q + 2'd1;
                    unique case (widx_q)
                        2'd0: cnt_q <= clamp_cnt(rdata_i);
                        2'd1: src_q <= AW'(rdata_i);
                        2'd2: dst_q <= AW'(rdata_i);
                        2'd3: begin nd_q <= AW'(rdata_i); fetch_q <= 1'b0; end
                    endcase
                end
                CH_READ: if (ack_i) buf_q <= rdata_i;
                CH_WRITE: if (ack_i) begin
                    src_q  <= src_q + sstep;
                    dst_q  <= dst_q + dstep;
                    beat_q <= beat_q + 6'd1;
                    if (last_beat) begin
                        cnt_q   <= '0;
                        stat_q  <= 1'b1;
                        fetch_q <= (nd_q != '0);
                    end else begin
                        cnt_q <= cnt_q - CW'(BEAT_BYTES);
                    end
                end
            endcase
            if (abort_now) begin
                en_q    <= 1'b0;
                fetch_q <= 1'b0;
                cnt_q   <= '0;
            end
        end
    end

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && !abort_now) |=> (req_o && $stable(addr_o) && $stable(we_o))); // R12
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_BYTES)); // R6
    AST_STAT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> $past(st_q == CH_WRITE && ack_i)); // R7
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_now |=> (st_q == CH_IDLE && !en_q && cnt_q == '0)); // R10
    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_IDLE && !en_q) |=> (st_q == CH_IDLE)); // R9
    AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_FETCH && ack_i && widx_q == 2'd3 && !wr_en) |=> (!fetch_q && st_q == CH_IDLE)); // R3

endmodule

// File: rtl/tdma_top.sv
module tdma_top
    import tdma_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int MAX_BYTES = 65536
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [7:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [31:0]    mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ack,
    input  logic [31:0]    mem_rdata,
    output logic [NCH-1:0] irq,
    output logic           irq_any
);
    localparam int AW = 32;

    logic [3:0]    slot;
    logic [1:0]    sel;
    logic          aligned;
    logic [NCH-1:0] ch_want, ch_busy, ch_gnt, ch_req, ch_we, ch_irq;
    logic [AW-1:0] ch_addr  [NCH];
    logic [31:0]   ch_wdata [NCH];
    logic [31:0]   ch_rd    [NCH];

    assign slot    = reg_addr[7:4];
    assign sel     = reg_addr[3:2];
    assign aligned = (reg_addr[1:0] == 2'b00);

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        tdma_channel #(.AW(AW), .MAX_BYTES(MAX_BYTES)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && aligned && (sel == 2'(gi))),
            .wr_slot (slot),
            .wr_data (reg_wdata),
            .rd_slot (slot),
            .rd_data (ch_rd[gi]),
            .gnt     (ch_gnt[gi]),
            .want    (ch_want[gi]),
            .busy    (ch_busy[gi]),
            .req_o   (ch_req[gi]),
            .we_o    (ch_we[gi]),
            .addr_o  (ch_addr[gi]),
            .wdata_o (ch_wdata[gi]),
            .ack_i   (mem_ack && ch_busy[gi]),
            .rdata_i (mem_rdata),
            .irq_o   (ch_irq[gi])
        );
    end

    tdma_arbiter #(.NCH(NCH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (ch_want),
        .busy  (ch_busy),
        .gnt   (ch_gnt)
    );

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_busy[i]) begin
                mem_req   = ch_req[i];
                mem_we    = ch_we[i];
                mem_addr  = ch_addr[i];
                mem_wdata = ch_wdata[i];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (aligned && sel == 2'(i)) reg_rdata = ch_rd[i];
        end
    end

    assign irq     = ch_irq;
    assign irq_any = |ch_irq;

endmodule

// File: tb/tb_tdma_top.sv
`timescale 1ns/1ps
module tb_tdma_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  irq;
    logic        irq_any;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mem [0:1023];

    // burst monitor for R5
    bit mon_on = 0;
    int last_ch = -1;
    int run_len = 0;
    int max_run = 0;

    tdma_top dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq), .irq_any(irq_any)
    );

    always #2.5 clk = ~clk;

    // memory model: acknowledges one cycle after a fresh request
    always @(negedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[11:2]] = mem_wdata;
                if (mon_on) begin
                    if (int'(mem_addr[11:8]) == last_ch + 13) run_len++;
                    else begin last_ch = int'(mem_addr[11:8]) - 13; run_len = 1; end
                    if (run_len > max_run) max_run = run_len;
                end
            end else mem_rdata <= mem[mem_addr[11:2]];
        end else mem_ack <= 1'b0;
    end

    function automatic [31:0] pat(input int a);
        return {16'hC0DE, 16'(a >> 2)};
    endfunction

    function automatic [7:0] ra(input [3:0] slot, input int ch);
        return {slot, 2'(ch), 2'b00};
    endfunction

    function automatic [31:0] cw(input bit en, input bit fe, input bit [2:0] bsz,
                                 input bit [1:0] sm, input bit [1:0] dm, input bit ab);
        return (32'(ab) << 20) | (32'(fe) << 13) | (32'(en) << 12) |
               (32'(bsz) << 6) | (32'(dm) << 4) | (32'(sm) << 2);
    endfunction

    task automatic check(input string req, input string what, input [31:0] act, input [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input [7:0] a, input [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_read(input [7:0] a, output [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic put_desc(input int a, input [31:0] c, input [31:0] s, input [31:0] d, input [31:0] n);
        mem[a >> 2] = c; mem[(a >> 2) + 1] = s; mem[(a >> 2) + 2] = d; mem[(a >> 2) + 3] = n;
    endtask

    task automatic wait_irq(input int ch, input string req);
        int n = 0;
        while (irq[ch] !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
        check(req, "completion interrupt", {31'b0, irq[ch]}, 32'd1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(ra(4'd0, 0), v);  check("R1", "ch0 count", v, 0);
        reg_read(ra(4'd4, 0), v);  check("R1", "ch0 control", v, 0);
        reg_read(ra(4'd4, 1), v);  check("R1", "ch1 control", v, 0);
        reg_read(ra(4'd10, 1), v); check("R1", "ch1 status", v, 0);
        check("R1", "irq lines", {29'b0, irq_any, irq}, 0);
        check("R1", "mem_req", {31'b0, mem_req}, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        reg_write(ra(4'd1, 0), 32'h1234);
        reg_write(ra(4'd1, 1), 32'hABCD0);
        reg_read(ra(4'd1, 0), v); check("R2", "ch0 source after ch1 write", v, 32'h1234);
        reg_read(ra(4'd1, 1), v); check("R2", "ch1 source", v, 32'hABCD0);
        reg_write(ra(4'd4, 1), 32'h0000_4000);
        reg_read(ra(4'd4, 1), v); check("R11", "active bit not writable", v, 0);
        reg_write(ra(4'd0, 1), 32'h0002_0000);
        reg_read(ra(4'd0, 1), v); check("R6", "count saturates", v, 32'h0001_0000);
        reg_write(ra(4'd0, 1), 32'h0);
    endtask

    task automatic t_single;
        logic [31:0] v;
        put_desc(32'h100, 16, 32'h400, 32'h800, 0);
        reg_write(ra(4'd8, 0), 1);
        reg_write(ra(4'd3, 0), 32'h100);
        reg_write(ra(4'd4, 0), cw(1, 1, 3'd1, 2'd0, 2'd0, 0));
        wait_irq(0, "R7");
        idle(5);
        for (int k = 0; k < 4; k++)
            check("R3", "copied word", mem[(32'h800 >> 2) + k], pat(32'h400 + 4 * k));
        reg_read(ra(4'd0, 0), v);  check("R6", "count at end", v, 0);
        reg_read(ra(4'd7, 0), v);  check("R3", "current descriptor", v, 32'h100);
        reg_read(ra(4'd1, 0), v);  check("R4", "source advanced", v, 32'h410);
        reg_read(ra(4'd4, 0), v);  check("R8", "idle after zero link", v[14], 0);
        check("R7", "irq_any", {31'b0, irq_any}, 1);
        reg_write(ra(4'd10, 0), 1);
        reg_read(ra(4'd10, 0), v); check("R7", "status write 1 keeps", v, 1);
        reg_write(ra(4'd10, 0), 0);
        check("R7", "irq after clear", {31'b0, irq[0]}, 0);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        put_desc(32'h110, 12, 32'h400, 32'h900, 0);
        reg_write(ra(4'd3, 0), 32'h110);
        reg_write(ra(4'd4, 0), cw(1, 1, 3'd0, 2'd0, 2'd2, 0));
        wait_irq(0, "R4");
        idle(5);
        check("R4", "held destination last word", mem[32'h900 >> 2], pat(32'h408));
        check("R4", "next word untouched", mem[(32'h900 >> 2) + 1], pat(32'h904));
        reg_read(ra(4'd2, 0), v); check("R4", "destination held", v, 32'h900);
        reg_write(ra(4'd10, 0), 0);
    endtask

    task automatic t_cyclic;
        put_desc(32'h200, 8, 32'h400, 32'hA00, 32'h210);
        put_desc(32'h210, 8, 32'h408, 32'hA10, 32'h200);
        reg_write(ra(4'd8, 1), 1);
        reg_write(ra(4'd3, 1), 32'h200);
        reg_write(ra(4'd4, 1), cw(1, 1, 3'd1, 2'd0, 2'd0, 0));
        for (int r = 0; r < 3; r++) begin
            wait_irq(1, "R8");
            reg_write(ra(4'd10, 1), 0);
        end
        reg_write(ra(4'd4, 1), cw(0, 0, 3'd1, 2'd0, 2'd0, 0));
        idle(40);
        check("R8", "ring word A1", mem[(32'hA00 >> 2) + 1], pat(32'h404));
        check("R8", "ring word B1", mem[(32'hA10 >> 2) + 1], pat(32'h40C));
        reg_write(ra(4'd4, 1), cw(0, 0, 3'd0, 2'd0, 2'd0, 1));
        reg_write(ra(4'd10, 1), 0);
    endtask

    task automatic t_pause;
        logic [31:0] c1, c2, v;
        put_desc(32'h120, 64, 32'h400, 32'hB00, 0);
        reg_write(ra(4'd3, 0), 32'h120);
        reg_write(ra(4'd4, 0), cw(1, 1, 3'd0, 2'd0, 2'd0, 0));
        idle(30);
        reg_write(ra(4'd4, 0), cw(0, 0, 3'd0, 2'd0, 2'd0, 0));
        idle(20);
        reg_read(ra(4'd0, 0), c1);
        check("R9", "partial count", {31'b0, (c1 != 0 && c1 < 64)}, 1);
        idle(30);
        reg_read(ra(4'd0, 0), c2);
        check("R9", "count frozen while paused", c2, c1);
        check("R9", "no request while paused", {31'b0, mem_req}, 0);
        reg_write(ra(4'd4, 0), cw(1, 0, 3'd0, 2'd0, 2'd0, 0));
        wait_irq(0, "R9");
        idle(5);
        for (int k = 0; k < 16; k++)
            check("R9", "resumed copy", mem[(32'hB00 >> 2) + k], pat(32'h400 + 4 * k));
        reg_read(ra(4'd0, 0), v); check("R9", "count after resume", v, 0);
        reg_write(ra(4'd10, 0), 0);
    endtask

    task automatic t_abort;
        logic [31:0] v;
        put_desc(32'h130, 64, 32'h400, 32'hC00, 0);
        reg_write(ra(4'd3, 0), 32'h130);
        reg_write(ra(4'd4, 0), cw(1, 1, 3'd7, 2'd0, 2'd0, 0));
        idle(15);
        reg_write(ra(4'd4, 0), cw(1, 0, 3'd7, 2'd0, 2'd0, 1));
        reg_read(ra(4'd0, 0), v);  check("R10", "count cleared", v, 0);
        reg_read(ra(4'd4, 0), v);
        check("R10", "enable cleared", v[12], 0);
        check("R10", "abort bit reads zero", v[20], 0);
        check("R11", "inactive after abort", v[14], 0);
        idle(100);
        check("R10", "no request after abort", {31'b0, mem_req}, 0);
        reg_read(ra(4'd10, 0), v); check("R10", "no completion", v, 0);
    endtask

    task automatic t_both;
        put_desc(32'h140, 32, 32'h400, 32'hD00, 0);
        put_desc(32'h150, 32, 32'h420, 32'hE00, 0);
        reg_write(ra(4'd3, 0), 32'h140);
        reg_write(ra(4'd3, 1), 32'h150);
        mon_on = 1;
        reg_write(ra(4'd4, 0), cw(1, 1, 3'd3, 2'd0, 2'd0, 0));
        reg_write(ra(4'd4, 1), cw(1, 1, 3'd3, 2'd0, 2'd0, 0));
        wait_irq(0, "R5");
        wait_irq(1, "R5");
        idle(5);
        mon_on = 0;
        check("R5", "longest run of one channel", max_run, 4);
        for (int k = 0; k < 8; k++) begin
            check("R5", "ch0 copy", mem[(32'hD00 >> 2) + k], pat(32'h400 + 4 * k));
            check("R5", "ch1 copy", mem[(32'hE00 >> 2) + k], pat(32'h420 + 4 * k));
        end
        reg_write(ra(4'd10, 0), 0);
        reg_write(ra(4'd10, 1), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = pat(i * 4);
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_regs;
        t_single;
        t_hold;
        t_cyclic;
        t_pause;
        t_abort;
        t_both;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule